// File: doc/BRIEF.md
# Global 64-bit Compare Timer

This block is a memory-mapped system timer. A free-running up-counter of twice the bus width (64 bits with the default 32-bit bus) advances once per clock while running. One comparator of the same width raises a sticky interrupt status when the count equals it. Each wide quantity is reached through a lower-half and an upper-half register on a simple single-cycle register bus. The upper half can be read, then the lower, then the upper again, retrying when the two upper reads differ.

In periodic mode every match adds a programmable step to the comparator, so the next match lands one step later with no software action. Every write to a counter half, a comparator half, the step or the control register sets a write-status bit one cycle after the write lands. Software clears that bit by writing a one to it. The interrupt output is the pending status gated by an enable register.

Top module: `gtmr_top`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: While control bit 0 (run) is set the counter rises by one on every clock. While it is clear the counter holds its value.
- R3: Writing offset 0x00 or 0x04 replaces only the lower or upper counter half with the bus data. The other half keeps its value, and the count carries on from the loaded value.
- R4: The lower half alone is a free-running count that wraps at 2^DW, and the wrap carries into the upper half.
- R5: The counter write-status register (0x08) holds bit 0 for a lower-half write and bit 1 for an upper-half write. Each bit is set one clock after the write takes effect. Writing 1 clears a bit, writing 0 leaves it, and a set arriving in the same clock as a clear wins.
- R6: The timing write-status register (0x24) behaves the same way, with bit 0 for comparator lower, bit 1 for comparator upper, bit 2 for the step and bit 3 for control.
- R7: Control (0x18) holds bit 0 run, bit 1 comparator enable and bit 2 periodic mode. With bit 1 clear, no match is ever recorded.
- R8: While the comparator is enabled and the counter equals the comparator (0x0C lower, 0x10 upper), bit 0 of the interrupt status register (0x1C) is set at the next clock.
- R9: In periodic mode each match adds the zero-extended step register (0x14) to the full-width comparator value in the same clock.
- R10: The pending status stays set until a write of bit 0 = 1 to 0x1C, and writing 0 leaves it set. A match in the same clock as the clear keeps it set.
- R11: `irq` equals pending status AND bit 0 of the interrupt enable register (0x20).
- R12: Register word offsets, in order, are: counter lower, counter upper, counter write-status, comparator lower, comparator upper, step, control, interrupt status, interrupt enable and timing write-status, each 4 bytes apart.
- R13: Reads of offset 0x28 and above, or of any address with nonzero low two bits, return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data, zero when not selected |
| irq | output | 1 | Comparator interrupt |

## Verification
The bench builds the block with an 8-bit bus and a 16-bit counter, with the step adder present. With that width the lower-half wrap and its carry into the upper half, and many periodic matches, all happen within a few hundred cycles. A behavioural model predicts every register value and `irq` on every clock. Clear writes are repeated through a periodic run, so a clear eventually lands in the same clock as a match.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

   typedef enum logic [3:0] {
      RI_CNT_LO   = 4'd0,
      RI_CNT_HI   = 4'd1,
      RI_CNT_WS   = 4'd2,
      RI_CMP_LO   = 4'd3,
      RI_CMP_HI   = 4'd4,
      RI_STEP     = 4'd5,
      RI_CTRL     = 4'd6,
      RI_IRQ_STAT = 4'd7,
      RI_IRQ_EN   = 4'd8,
      RI_WS       = 4'd9
   } reg_idx_e;

   localparam int CTRL_W      = 3;
   localparam int CTRL_RUN    = 0;
   localparam int CTRL_CMP_EN = 1;
   localparam int CTRL_AUTO   = 2;

   localparam int CWS_W     = 2;
   localparam int WS_W      = 4;
   localparam int WS_CMP_LO = 0;
   localparam int WS_CMP_HI = 1;
   localparam int WS_STEP   = 2;
   localparam int WS_CTRL   = 3;

endpackage

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
   parameter int HW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [1:0]    ld,
   input  logic [HW-1:0] ld_data,
   output logic [2*HW-1:0] cnt
);
   localparam int CW = 2 * HW;

   logic [CW-1:0] inc;
   logic [CW-1:0] nxt;

   assign inc = cnt + CW'(1);

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign nxt[h*HW +: HW] = ld[h] ? ld_data :
                               ((|ld) || !run) ? cnt[h*HW +: HW] : inc[h*HW +: HW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

   // R2: running counter advances by exactly one
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(|ld)) |=> (cnt == $past(cnt) + CW'(1)));

   // R2: stopped counter holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(|ld)) |=> $stable(cnt));

   // R3: a lower-half load leaves the upper half alone
   a_r3_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld[0] |=> (cnt[HW-1:0] == $past(ld_data)) && (cnt[CW-1:HW] == $past(cnt[CW-1:HW])));

endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
   parameter int HW       = 32,
   parameter bit HAS_STEP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2*HW-1:0] cnt,
   input  logic            en,
   input  logic            auto_adv,
   input  logic [1:0]      ld,
   input  logic [HW-1:0]   ld_data,
   input  logic [HW-1:0]   step,
   output logic [2*HW-1:0] cmp,
   output logic            hit
);
   localparam int CW = 2 * HW;

   logic [CW-1:0] adv;
   logic [CW-1:0] nxt;

   assign hit = en && (cnt == cmp);

   if (HAS_STEP) begin : g_step
      assign adv = cmp + CW'(step);

      // R9: periodic mode moves the comparator by the step on a match
      a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && auto_adv && !(|ld)) |=> (cmp == $past(cmp) + CW'($past(step))));
   end else begin : g_nostep
      assign adv = cmp;
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign nxt[h*HW +: HW] = ld[h] ? ld_data :
                               ((|ld) || !(hit && auto_adv)) ? cmp[h*HW +: HW] : adv[h*HW +: HW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp <= '0;
      else        cmp <= nxt;
   end

   // R7: without a match the comparator only changes through a load
   a_r7_cmp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !(|ld)) |=> $stable(cmp));

endmodule

// File: rtl/gtmr_wstat.sv
module gtmr_wstat #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] stat
);
   logic [N-1:0] req_q;
   logic [N-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         stat  <= '0;
      end else begin
         req_q <= req;
         stat  <= (stat & ~clr_eff) | req_q;
      end
   end

   // R5 / R6: a write shows up in the status two edges after it is presented
   a_r5_set_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> ##2 ((stat & $past(req, 2)) == $past(req, 2)));

   // R6: write-one clears a bit that is not being set again
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((stat & $past(clr_mask & ~req_q)) == '0));

endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
   import gtmr_pkg::*;
#(
   parameter int DW       = 32,
   parameter int ADDR_W   = 6,
   parameter bit HAS_STEP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   localparam int CW    = 2 * DW;
   localparam int IDX_W = ADDR_W - 2;

   if (DW < WS_W) begin : g_bad_dw
      $error("gtmr_top: DW must be at least %0d", WS_W);
   end
   if (ADDR_W < 6) begin : g_bad_aw
      $error("gtmr_top: ADDR_W must be at least 6");
   end

   logic [IDX_W-1:0] idx;
   logic             aligned;
   logic             we;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign we      = bus_sel && bus_wr && aligned;

   logic wr_cnt_lo, wr_cnt_hi, wr_cws, wr_cmp_lo, wr_cmp_hi;
   logic wr_step, wr_ctrl, wr_istat, wr_ien, wr_ws;

   assign wr_cnt_lo = we && (idx == IDX_W'(RI_CNT_LO));
   assign wr_cnt_hi = we && (idx == IDX_W'(RI_CNT_HI));
   assign wr_cws    = we && (idx == IDX_W'(RI_CNT_WS));
   assign wr_cmp_lo = we && (idx == IDX_W'(RI_CMP_LO));
   assign wr_cmp_hi = we && (idx == IDX_W'(RI_CMP_HI));
   assign wr_step   = we && (idx == IDX_W'(RI_STEP));
   assign wr_ctrl   = we && (idx == IDX_W'(RI_CTRL));
   assign wr_istat  = we && (idx == IDX_W'(RI_IRQ_STAT));
   assign wr_ien    = we && (idx == IDX_W'(RI_IRQ_EN));
   assign wr_ws     = we && (idx == IDX_W'(RI_WS));

   logic [CTRL_W-1:0] ctrl;
   logic [DW-1:0]     step;
   logic              ien;
   logic              pend;
   logic              clr_pend;

   assign clr_pend = wr_istat && bus_wdata[0];

   logic [CW-1:0]    cnt;
   logic [CW-1:0]    cmp;
   logic             hit;
   logic [CWS_W-1:0] cws;
   logic [WS_W-1:0]  ws;
   logic [WS_W-1:0]  ws_req;

   gtmr_counter #(.HW(DW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl[CTRL_RUN]),
      .ld      ({wr_cnt_hi, wr_cnt_lo}),
      .ld_data (bus_wdata),
      .cnt     (cnt)
   );

   gtmr_compare #(.HW(DW), .HAS_STEP(HAS_STEP)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .en       (ctrl[CTRL_CMP_EN]),
      .auto_adv (ctrl[CTRL_AUTO]),
      .ld       ({wr_cmp_hi, wr_cmp_lo}),
      .ld_data  (bus_wdata),
      .step     (step),
      .cmp      (cmp),
      .hit      (hit)
   );

   gtmr_wstat #(.N(CWS_W)) u_cws (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      ({wr_cnt_hi, wr_cnt_lo}),
      .clr_we   (wr_cws),
      .clr_mask (bus_wdata[CWS_W-1:0]),
      .stat     (cws)
   );

   always_comb begin
      ws_req            = '0;
      ws_req[WS_CMP_LO] = wr_cmp_lo;
      ws_req[WS_CMP_HI] = wr_cmp_hi;
      ws_req[WS_STEP]   = wr_step;
      ws_req[WS_CTRL]   = wr_ctrl;
   end

   gtmr_wstat #(.N(WS_W)) u_ws (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (ws_req),
      .clr_we   (wr_ws),
      .clr_mask (bus_wdata[WS_W-1:0]),
      .stat     (ws)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         step <= '0;
         ien  <= 1'b0;
         pend <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= bus_wdata[CTRL_W-1:0];
         if (wr_step) step <= bus_wdata;
         if (wr_ien)  ien  <= bus_wdata[0];
         if (hit)           pend <= 1'b1;
         else if (clr_pend) pend <= 1'b0;
      end
   end

   assign irq = pend && ien;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && aligned) begin
         case (idx)
            IDX_W'(RI_CNT_LO):   bus_rdata = cnt[DW-1:0];
            IDX_W'(RI_CNT_HI):   bus_rdata = cnt[CW-1:DW];
            IDX_W'(RI_CNT_WS):   bus_rdata = DW'(cws);
            IDX_W'(RI_CMP_LO):   bus_rdata = cmp[DW-1:0];
            IDX_W'(RI_CMP_HI):   bus_rdata = cmp[CW-1:DW];
            IDX_W'(RI_STEP):     bus_rdata = step;
            IDX_W'(RI_CTRL):     bus_rdata = DW'(ctrl);
            IDX_W'(RI_IRQ_STAT): bus_rdata = DW'(pend);
            IDX_W'(RI_IRQ_EN):   bus_rdata = DW'(ien);
            IDX_W'(RI_WS):       bus_rdata = DW'(ws);
            default:             bus_rdata = '0;
         endcase
      end
   end

   // R8: an enabled match records a pending interrupt
   a_r8_hit_latch: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pend);

   // R10: pending is sticky until a write-one clear
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr_pend) |=> pend);

   // R10: a clear without a coincident match drops the status
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend && !hit) |=> !pend);

   // R7: comparator disabled means nothing new becomes pending
   a_r7_no_hit_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[CTRL_CMP_EN] && !pend) |=> !pend);

endmodule

// File: tb/sim_gtmr_top.sv
`timescale 1ns/1ps
module sim_gtmr_top;
   localparam int DW = 8;
   localparam int AW = 6;
   localparam logic [5:0] A_CNT_LO = 6'd0,  A_CNT_HI = 6'd4,  A_CWS  = 6'd8;
   localparam logic [5:0] A_CMP_LO = 6'd12, A_CMP_HI = 6'd16, A_STEP = 6'd20;
   localparam logic [5:0] A_CTRL   = 6'd24, A_ISTAT  = 6'd28, A_IEN  = 6'd32;
   localparam logic [5:0] A_WS     = 6'd36, A_BAD    = 6'd40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic b_sel = 1'b0, b_wr = 1'b0;
   logic [AW-1:0] b_addr = '0;
   logic [DW-1:0] b_wd = '0;
   logic [DW-1:0] bus_rdata;
   logic irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   bit chk_on = 1'b0;
   string phase = "R1";

   always #10 clk = ~clk;

   gtmr_top #(.DW(DW), .ADDR_W(AW), .HAS_STEP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr),
      .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference state
   logic [15:0] m_cnt, m_cmp;
   logic [7:0]  m_step;
   logic [2:0]  m_ctrl;
   logic        m_pend, m_ien;
   logic [3:0]  m_ws, m_ws_p;
   logic [1:0]  m_cws, m_cws_p;

   task automatic check(input string t, input string what, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [5:0] a);
      case (a)
         A_CNT_LO: return m_cnt[7:0];
         A_CNT_HI: return m_cnt[15:8];
         A_CWS:    return {6'b0, m_cws};
         A_CMP_LO: return m_cmp[7:0];
         A_CMP_HI: return m_cmp[15:8];
         A_STEP:   return m_step;
         A_CTRL:   return {5'b0, m_ctrl};
         A_ISTAT:  return {7'b0, m_pend};
         A_IEN:    return {7'b0, m_ien};
         A_WS:     return {4'b0, m_ws};
         default:  return 8'h00;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin : mdl
      logic w, match;
      logic [15:0] n_cnt, n_cmp;
      logic [3:0] n_ws;
      logic [1:0] n_cws;
      if (!rst_n) begin
         m_cnt = '0; m_cmp = '0; m_step = '0; m_ctrl = '0;
         m_pend = 1'b0; m_ien = 1'b0;
         m_ws = '0; m_ws_p = '0; m_cws = '0; m_cws_p = '0;
      end else begin
         w = b_sel && b_wr;
         match = m_ctrl[1] && (m_cnt == m_cmp);
         n_cnt = m_cnt;
         if (w && b_addr == A_CNT_LO)      n_cnt[7:0] = b_wd;
         else if (w && b_addr == A_CNT_HI) n_cnt[15:8] = b_wd;
         else if (m_ctrl[0])               n_cnt = m_cnt + 16'd1;
         n_cmp = m_cmp;
         if (w && b_addr == A_CMP_LO)      n_cmp[7:0] = b_wd;
         else if (w && b_addr == A_CMP_HI) n_cmp[15:8] = b_wd;
         else if (match && m_ctrl[2])      n_cmp = m_cmp + {8'd0, m_step};
         n_cws = (m_cws & ~((w && b_addr == A_CWS) ? b_wd[1:0] : 2'b00)) | m_cws_p;
         n_ws  = (m_ws  & ~((w && b_addr == A_WS)  ? b_wd[3:0] : 4'b0000)) | m_ws_p;
         m_cws_p = {w && b_addr == A_CNT_HI, w && b_addr == A_CNT_LO};
         m_ws_p  = {w && b_addr == A_CTRL, w && b_addr == A_STEP,
                    w && b_addr == A_CMP_HI, w && b_addr == A_CMP_LO};
         if (match) m_pend = 1'b1;
         else if (w && b_addr == A_ISTAT && b_wd[0]) m_pend = 1'b0;
         if (w && b_addr == A_CTRL) m_ctrl = b_wd[2:0];
         if (w && b_addr == A_STEP) m_step = b_wd;
         if (w && b_addr == A_IEN)  m_ien = b_wd[0];
         m_cnt = n_cnt; m_cmp = n_cmp; m_cws = n_cws; m_ws = n_ws;
      end
   end

   // every-cycle comparison against the model (R11 for irq, phase tag for data)
   always @(negedge clk) begin
      if (rst_n && chk_on && !done) begin
         check("R11", "irq", {7'b0, irq}, {7'b0, m_pend & m_ien});
         if (b_sel) check(phase, "rdata", bus_rdata, m_read(b_addr));
      end
   end

   task automatic put(input logic wr, input logic [5:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      b_sel = 1'b1; b_wr = wr; b_addr = a; b_wd = d;
   endtask

   task automatic wreg(input logic [5:0] a, input logic [7:0] d);
      put(1'b1, a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) put(1'b0, 6'((i % 10) * 4), 8'h00);
   endtask

   task automatic peekv(input logic [5:0] a, output logic [7:0] v);
      put(1'b0, a, 8'h00);
      @(negedge clk); #2;
      v = bus_rdata;
   endtask

   task automatic peek(input logic [5:0] a, input logic [7:0] exp, input string t);
      logic [7:0] v;
      peekv(a, v);
      check(t, "literal", v, exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v1, v2, c, p;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      chk_on = 1'b1;

      // R1 / R12: everything zero after reset at each offset
      phase = "R1";
      for (int i = 0; i < 10; i++) peek(6'(i * 4), 8'h00, "R1");
      check("R1", "irq", {7'b0, irq}, 8'h00);
      peek(A_BAD, 8'h00, "R13");

      // R3 / R5: half loads and counter write-status
      phase = "R3";
      wreg(A_CNT_LO, 8'h34);
      peek(A_CNT_LO, 8'h34, "R3");
      peek(A_CWS, 8'h01, "R5");
      wreg(A_CNT_HI, 8'h12);
      peek(A_CNT_HI, 8'h12, "R3");
      peek(A_CNT_LO, 8'h34, "R3");
      peek(A_CWS, 8'h03, "R5");
      wreg(A_CWS, 8'h00);
      peek(A_CWS, 8'h03, "R5");
      wreg(A_CWS, 8'h01);
      peek(A_CWS, 8'h02, "R5");
      wreg(A_CWS, 8'h02);
      peek(A_CWS, 8'h00, "R5");

      // R2 / R6 / R7: run and stop
      phase = "R2";
      wreg(A_CTRL, 8'h01);
      peek(A_WS, 8'h08, "R6");
      peek(A_CTRL, 8'h01, "R7");
      idle(12);
      wreg(A_CTRL, 8'h00);
      peekv(A_CNT_LO, v1);
      idle(5);
      peekv(A_CNT_LO, v2);
      check("R2", "hold", v2, v1);
      wreg(A_WS, 8'h08);
      peek(A_WS, 8'h00, "R6");

      // R4: lower wrap carries into upper
      phase = "R4";
      wreg(A_CNT_LO, 8'hFE);
      wreg(A_CNT_HI, 8'h00);
      wreg(A_CTRL, 8'h01);
      idle(4);
      peek(A_CNT_HI, 8'h01, "R4");
      idle(300);

      // R8 / R10 / R11: single match
      phase = "R8";
      wreg(A_CTRL, 8'h00);
      wreg(A_CNT_LO, 8'h00);
      wreg(A_CNT_HI, 8'h00);
      wreg(A_CMP_LO, 8'h10);
      wreg(A_CMP_HI, 8'h00);
      wreg(A_IEN, 8'h01);
      wreg(A_WS, 8'h0F);
      peek(A_IRQ_STAT_ALIAS(), 8'h00, "R8");
      wreg(A_CTRL, 8'h03);
      idle(30);
      peek(A_ISTAT, 8'h01, "R8");
      check("R11", "irq on", {7'b0, irq}, 8'h01);
      peek(A_CMP_LO, 8'h10, "R8");
      wreg(A_IEN, 8'h00);
      peek(A_ISTAT, 8'h01, "R10");
      check("R11", "irq masked", {7'b0, irq}, 8'h00);
      wreg(A_ISTAT, 8'h00);
      peek(A_ISTAT, 8'h01, "R10");
      wreg(A_ISTAT, 8'h01);
      peek(A_ISTAT, 8'h00, "R10");

      // R9: periodic mode
      phase = "R9";
      wreg(A_CTRL, 8'h00);
      wreg(A_CNT_LO, 8'h00);
      wreg(A_CNT_HI, 8'h00);
      wreg(A_CMP_LO, 8'h05);
      wreg(A_CMP_HI, 8'h00);
      wreg(A_STEP, 8'h07);
      peek(A_STEP, 8'h07, "R12");
      wreg(A_IEN, 8'h01);
      wreg(A_CTRL, 8'h07);
      peek(A_CTRL, 8'h07, "R12");
      idle(40);
      wreg(A_CTRL, 8'h00);
      peekv(A_CNT_LO, c);
      peekv(A_CMP_LO, p);
      check("R9", "cmp ahead", {7'b0, (p >= c) && ((p - c) <= 8'd6)}, 8'h01);
      check("R9", "cmp on grid", (p - 8'd5) % 8'd7, 8'h00);
      check("R9", "moved", {7'b0, p > 8'd20}, 8'h01);

      // R10: clears hammered during periodic matches
      phase = "R10";
      wreg(A_CTRL, 8'h07);
      for (int i = 0; i < 30; i++) wreg(A_ISTAT, 8'h01);
      idle(20);

      // R7: comparator disabled never matches
      phase = "R7";
      wreg(A_CTRL, 8'h00);
      wreg(A_ISTAT, 8'h01);
      wreg(A_CMP_LO, 8'h50);
      wreg(A_CMP_HI, 8'h00);
      wreg(A_CNT_LO, 8'h40);
      wreg(A_CNT_HI, 8'h00);
      wreg(A_CTRL, 8'h05);
      idle(30);
      peek(A_ISTAT, 8'h00, "R7");
      peek(A_CMP_LO, 8'h50, "R7");

      // R13: unmapped and unaligned accesses
      phase = "R13";
      wreg(A_CTRL, 8'h00);
      wreg(A_BAD, 8'hFF);
      wreg(6'd25, 8'hFF);
      peek(A_BAD, 8'h00, "R13");
      peek(6'd25, 8'h00, "R13");
      peek(A_CTRL, 8'h00, "R13");
      peek(A_STEP, 8'h07, "R13");
      idle(12);

      finish_run();
   end

   function automatic logic [5:0] A_IRQ_STAT_ALIAS();
      return A_ISTAT;
   endfunction

endmodule